// File: doc/BRIEF.md
# Serial Relay Driver Controller

This block lets a backplane controller talk to a plug-in switch card over a short serial link. A host loads a 40-bit relay pattern on a parallel port and pulses start. The block then sends the pattern most significant bit first on a data line, timed by a relay clock derived from the system clock. After the last bit it raises a strobe for one relay-clock period, which latches the pattern into the card's drivers.

The same link also carries reads. With the read select high at start, the block raises the read/write line. It clocks 40 bits in from the card's I/O data line and hands the assembled word to the host with a one-cycle valid pulse. The card-select line is high for the whole of either transaction.

An enable line tells the card that its drivers may act. It stays low after reset and goes high in the same cycle as the strobe of the first completed transfer, whether that transfer is a read or a write. It then stays high until reset.

Top module: `relay_ser_ctrl`

## Requirements
- R1: While reset is asserted and after its release, until the first start, busy, done, rd_valid, rly_clk, rly_dat, rly_stb, rly_en, rly_cs and rly_rw are all 0.
- R2: A start pulse sampled while idle makes busy and rly_cs go high in the next cycle. rly_rw then equals the read select sampled with start (1 = read, 0 = write) for as long as busy is high, and rly_rw is 0 whenever busy is low.
- R3: The relay clock starts low, has a period of DIV system cycles (DIV/2 low, then DIV/2 high), and runs for exactly 40 periods per transaction.
- R4: In a write, bit 39 of the pattern is on rly_dat during the first relay-clock period and bit 39-k during period k. Data changes only while the relay clock falls, never while it is high.
- R5: In a read, io_dat is sampled at each rising relay-clock edge. The first sample lands in bit 39 of rd_data and the last sample in bit 0. rd_data is updated, and rd_valid pulses for one cycle, in the cycle busy falls; rd_valid stays 0 for writes.
- R6: After the 40th falling relay-clock edge, rly_stb is high for exactly DIV system cycles while the relay clock is held low.
- R7: rly_en goes high in the same cycle as the first strobe after reset, for a read or a write, and never falls before the next reset.
- R8: busy stays high from the cycle after start until the strobe ends. done is high for exactly one cycle, the first cycle with busy low.
- R9: A start pulse while busy is ignored. The pattern on the data line, the read/write direction and the frame length are not affected.
- R10: During a read, rly_dat is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transaction (sampled while idle) |
| rd_i | input | 1 | Transaction type at start: 1 read, 0 write |
| wr_data_i | input | NBITS | Relay pattern for a write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse at transaction end |
| rd_data_o | output | NBITS | Word captured by the last read |
| rd_valid_o | output | 1 | One-cycle pulse when rd_data_o is updated |
| rly_clk_o | output | 1 | Serial relay clock |
| rly_dat_o | output | 1 | Serial relay data to the card |
| rly_stb_o | output | 1 | Latch strobe |
| rly_en_o | output | 1 | Card driver enable |
| rly_cs_o | output | 1 | Card select |
| rly_rw_o | output | 1 | Read/write direction, 1 = read |
| io_dat_i | input | 1 | Serial I/O data from the card |

## Verification
Call the edge that samples start cycle 0. Busy, card select and direction are due one cycle later. Bit k of the frame occupies cycles k*DIV+1 through (k+1)*DIV; its rising relay-clock edge is the edge after cycle k*DIV+DIV/2. The strobe covers cycles 40*DIV+1 through 41*DIV, and done, rd_valid and rd_data are due one cycle after that. The bench counts an offset from the start edge and compares every output on the falling clock edge that follows each rising edge. It drives the card's data bit half a cycle before the rising relay-clock edge that is meant to sample it.

// File: rtl/relay_ser_pkg.sv
package relay_ser_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_STRB  = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/rly_tick_gen.sv
module rly_tick_gen #(
  parameter int DIV = 8,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] lim_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == lim_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the divider never passes its wrap limit
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= lim_i));
  // R3: the counter is cleared whenever the divider is stopped
  a_r3_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/rly_shift_reg.sv
module rly_shift_reg #(
  parameter int NBITS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NBITS-1:0] load_val_i,
  input  logic             shl_i,
  input  logic             in_bit_i,
  output logic [NBITS-1:0] q_o
);
  logic [NBITS-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)     sr_d = load_val_i;
    else if (shl_i) sr_d = {sr_q[NBITS-2:0], in_bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q_o = sr_q;

  // R4/R5: a load never coincides with a shift
  a_r4_no_load_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && shl_i));
endmodule

// File: rtl/relay_ser_ctrl.sv
module relay_ser_ctrl
  import relay_ser_pkg::*;
#(
  parameter int NBITS = 40,
  parameter int DIV   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [NBITS-1:0] wr_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NBITS-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             rly_clk_o,
  output logic             rly_dat_o,
  output logic             rly_stb_o,
  output logic             rly_en_o,
  output logic             rly_cs_o,
  output logic             rly_rw_o,
  input  logic             io_dat_i
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW   = (NBITS > 1) ? $clog2(NBITS) : 1;

  xfer_state_t      st_q, st_d;
  logic             clk_q, clk_d;
  logic             stb_q, stb_d;
  logic             en_q, en_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             rdv_q, rdv_d;
  logic             rd_q, rd_d;
  logic [BW-1:0]    bcnt_q, bcnt_d;
  logic [NBITS-1:0] rdat_q, rdat_d;

  logic             tick;
  logic [CW-1:0]    lim;
  logic             rise, fall, load, shl;
  logic [NBITS-1:0] sr;

  assign lim = (st_q == ST_STRB) ? CW'(DIV - 1) : CW'(HALF - 1);

  rly_tick_gen #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_q),
    .lim_i  (lim),
    .tick_o (tick)
  );

  assign rise = (st_q == ST_SHIFT) && tick && !clk_q;
  assign fall = (st_q == ST_SHIFT) && tick &&  clk_q;
  assign load = (st_q == ST_IDLE) && start_i;
  assign shl  = rd_q ? rise : fall;

  rly_shift_reg #(.NBITS(NBITS)) u_sr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (rd_i ? '0 : wr_data_i),
    .shl_i      (shl),
    .in_bit_i   (rd_q & io_dat_i),
    .q_o        (sr)
  );

  always_comb begin
    st_d   = st_q;
    clk_d  = clk_q;
    stb_d  = stb_q;
    en_d   = en_q;
    busy_d = busy_q;
    done_d = 1'b0;
    rdv_d  = 1'b0;
    rd_d   = rd_q;
    bcnt_d = bcnt_q;
    rdat_d = rdat_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_SHIFT;
          busy_d = 1'b1;
          rd_d   = rd_i;
          bcnt_d = '0;
          clk_d  = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          clk_d = !clk_q;
          if (clk_q) begin
            if (bcnt_q == BW'(NBITS - 1)) begin
              st_d  = ST_STRB;
              stb_d = 1'b1;
              en_d  = 1'b1;
            end else begin
              bcnt_d = bcnt_q + 1'b1;
            end
          end
        end
      end
      ST_STRB: begin
        if (tick) begin
          st_d   = ST_IDLE;
          stb_d  = 1'b0;
          busy_d = 1'b0;
          done_d = 1'b1;
          if (rd_q) begin
            rdv_d  = 1'b1;
            rdat_d = sr;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      clk_q  <= 1'b0;
      stb_q  <= 1'b0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      rd_q   <= 1'b0;
      bcnt_q <= '0;
      rdat_q <= '0;
    end else begin
      st_q   <= st_d;
      clk_q  <= clk_d;
      stb_q  <= stb_d;
      en_q   <= en_d;
      busy_q <= busy_d;
      done_q <= done_d;
      rdv_q  <= rdv_d;
      rd_q   <= rd_d;
      bcnt_q <= bcnt_d;
      rdat_q <= rdat_d;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdat_q;
  assign rly_clk_o  = clk_q;
  assign rly_stb_o  = stb_q;
  assign rly_en_o   = en_q;
  assign rly_cs_o   = busy_q;
  assign rly_rw_o   = busy_q & rd_q;
  assign rly_dat_o  = (st_q == ST_SHIFT) & ~rd_q & sr[NBITS-1];

  // R7: enable never drops once raised
  a_r7_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rly_en_o |=> rly_en_o);
  // R7: enable first rises together with a strobe
  a_r7_en_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rly_en_o) |-> $rose(rly_stb_o));
  // R6: relay clock held low during the strobe
  a_r6_clk_low_stb: assert property (@(posedge clk) disable iff (!rst_n)
    rly_stb_o |-> !rly_clk_o);
  // R4: data steady while the relay clock stays high
  a_r4_dat_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rly_clk_o && $past(rly_clk_o)) |-> $stable(rly_dat_o));
  // R8: done follows the fall of busy, for one cycle
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: read valid only with done
  a_r5_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> done_o);
  // R10: data line quiet during reads
  a_r10_dat_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
    rly_rw_o |-> !rly_dat_o);
  // R9: direction held for the whole transaction
  a_r9_rw_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rly_rw_o));
endmodule

// File: tb/test_relay_ser_ctrl.sv
`timescale 1ns/1ps
module test_relay_ser_ctrl;
  localparam int N    = 40;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         rd_i;
  logic [N-1:0] wr_data_i;
  logic         busy_o, done_o, rd_valid_o;
  logic [N-1:0] rd_data_o;
  logic         rly_clk_o, rly_dat_o, rly_stb_o, rly_en_o, rly_cs_o, rly_rw_o;
  logic         io_dat_i;

  int total = 0;
  int bad   = 0;
  bit en_seen = 0;

  relay_ser_ctrl #(.NBITS(N), .DIV(DIV)) i_relay_ser_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
    .wr_data_i(wr_data_i), .busy_o(busy_o), .done_o(done_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .rly_clk_o(rly_clk_o), .rly_dat_o(rly_dat_o), .rly_stb_o(rly_stb_o),
    .rly_en_o(rly_en_o), .rly_cs_o(rly_cs_o), .rly_rw_o(rly_rw_o),
    .io_dat_i(io_dat_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "busy", N'(busy_o), '0);
    chk(req, "clk",  N'(rly_clk_o), '0);
    chk(req, "dat",  N'(rly_dat_o), '0);
    chk(req, "stb",  N'(rly_stb_o), '0);
    chk(req, "cs",   N'(rly_cs_o), '0);
    chk(req, "rw",   N'(rly_rw_o), '0);
    chk(req, "en",   N'(rly_en_o), N'(en_seen));
  endtask

  function automatic logic exp_rclk(int t);
    return ((t % DIV) >= HALF);
  endfunction

  // one transaction; inject = start pulse with other data while busy (R9)
  task automatic run_tx(input bit rd, input logic [N-1:0] wd,
                        input logic [N-1:0] rdat, input bit inject);
    start_i   = 1'b1;
    rd_i      = rd;
    wr_data_i = wd;
    @(posedge clk);
    for (int t = 0; t <= 41 * DIV + 1; t++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (inject && t == 3 * DIV + 1) begin
        start_i   = 1'b1;
        rd_i      = ~rd;
        wr_data_i = ~wd;
      end
      if (t < 40 * DIV) io_dat_i = rdat[N - 1 - (t / DIV)];
      else              io_dat_i = 1'b0;
      if (t < 40 * DIV) begin
        chk("R2", "busy", N'(busy_o), N'(1));
        chk("R2", "cs",   N'(rly_cs_o), N'(1));
        chk(inject ? "R9" : "R2", "rw", N'(rly_rw_o), N'(rd));
        chk("R3", "rclk", N'(rly_clk_o), N'(exp_rclk(t)));
        if (rd) chk("R10", "dat", N'(rly_dat_o), '0);
        else    chk(inject ? "R9" : "R4", "dat", N'(rly_dat_o), N'(wd[N - 1 - (t / DIV)]));
        chk("R6", "stb", N'(rly_stb_o), '0);
        chk("R7", "en",  N'(rly_en_o), N'(en_seen));
      end else if (t < 41 * DIV) begin
        en_seen = 1;
        chk("R6", "stb",  N'(rly_stb_o), N'(1));
        chk("R6", "rclk", N'(rly_clk_o), '0);
        chk("R7", "en",   N'(rly_en_o), N'(1));
        chk("R8", "busy", N'(busy_o), N'(1));
        chk("R8", "done", N'(done_o), '0);
      end else if (t == 41 * DIV) begin
        chk("R8", "busy", N'(busy_o), '0);
        chk("R8", "done", N'(done_o), N'(1));
        chk("R6", "stb",  N'(rly_stb_o), '0);
        chk("R5", "valid", N'(rd_valid_o), N'(rd));
        if (rd) chk("R5", "rd_data", rd_data_o, rdat);
        chk("R2", "rw", N'(rly_rw_o), '0);
      end else begin
        chk("R8", "done", N'(done_o), '0);
        chk("R5", "valid", N'(rd_valid_o), '0);
        chk_idle("R8");
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rd_i = 1'b0; wr_data_i = '0; io_dat_i = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk_idle("R1");
    chk("R1", "done", N'(done_o), '0);
    chk("R1", "valid", N'(rd_valid_o), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    chk("R1", "done", N'(done_o), '0);
    // first transfer is a read: enable must rise with its strobe (R7)
    run_tx(1'b1, '0, 40'hA5_C3_0F_96_E1, 1'b0);
    run_tx(1'b0, 40'hFF_FF_FF_FF_FF, '0, 1'b0);
    run_tx(1'b0, 40'h00_00_00_00_00, '0, 1'b0);
    run_tx(1'b0, 40'hAA_AA_AA_AA_AA, '0, 1'b0);
    run_tx(1'b0, 40'h80_00_00_00_01, '0, 1'b1);
    run_tx(1'b1, '0, 40'h80_00_00_00_01, 1'b1);
    run_tx(1'b1, '0, 40'hFF_FF_FF_FF_FF, 1'b0);
    for (int i = 0; i < 8; i++) begin
      logic [N-1:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      run_tx(1'($urandom & 1), a, b, 1'($urandom & 1));
      if ($urandom % 2) @(negedge clk);
    end
    // reset mid-transaction restores the reset state (R1)
    start_i = 1'b1; rd_i = 1'b0; wr_data_i = '1;
    @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0; en_seen = 0;
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule